// File: doc/BRIEF.md
# Shift, Rotate and Bitwise Logic Execution Unit

This block is the execution slice for one family of 32-bit register-to-register operations in a processor core. It takes a destination operand and a source operand, plus a 4-bit operation code. Every operation produces a 32-bit result in the same cycle. There are rotates, logical shifts, carry-fed rotates, an arithmetic right shift, a variable-width bit mirror, four bitwise logic functions and four mask-driven merges, in which a flag value is copied into selected bits.

The block keeps the zero flag and the carry flag in registers of its own. The current flag values feed the operations that consume them: the carry-fed rotates and the merges. At the clock edge each flag takes its newly computed value, but only if that flag's own write strobe is high. Otherwise the flag keeps its old value. Operand fetch, decoding, predication and result write-back belong to the surrounding pipeline.

Top module: `bitops_exec`

## Requirements
- R1: Only bits [4:0] of `opd_s` set the shift, rotate or mirror amount n, from 0 to 31. The upper bits of `opd_s` have no effect on these operations.
- R2: Op 0 rotates `opd_d` right by n. Op 1 rotates it left by n.
- R3: Op 2 shifts right by n and op 3 shifts left by n, filling the vacated bits with 0.
- R4: Op 4 shifts right by n and op 5 shifts left by n, filling the vacated bits with the current carry flag.
- R5: Op 6 shifts right by n and fills the vacated upper bits with `opd_d[31]`.
- R6: Op 7 places the low 32-n bits of `opd_d` in reversed order into result bits [31-n:0] and clears the upper n bits.
- R7: The new carry is the original `opd_d[0]` for ops 0, 2, 4, 6 and 7, and the original `opd_d[31]` for ops 1, 3 and 5.
- R8: The logic ops compute d AND NOT s (op 8), d AND s (op 9), d OR s (op 10) and d XOR s (op 11). For these ops the new carry is the XOR of all 32 result bits.
- R9: In every bit where `opd_s` is 1, the merge ops write the carry flag (op 12), the inverted carry flag (op 13), the zero flag (op 14) or the inverted zero flag (op 15). All other bits keep their `opd_d` value. The new carry is the result parity.
- R10: For every op, the new zero flag is 1 exactly when the 32-bit result is 0.
- R11: A flag takes its new value at the clock edge only when its strobe (`wr_z` or `wr_c`) is high. Otherwise it holds its value.
- R12: Reset clears both flags to 0.
- R13: When n is 0, ops 0 through 6 return `opd_d` unchanged, and the carry still comes from the end bit given in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flags update on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opd_d | input | 32 | Destination operand |
| opd_s | input | 32 | Source operand or mask |
| op | input | 4 | Operation code, as listed in R2 to R9 |
| wr_z | input | 1 | Zero flag write strobe |
| wr_c | input | 1 | Carry flag write strobe |
| result | output | 32 | Combinational result |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry flag |

## Verification
The only state in the block is the two flag bits. A wrong flag becomes visible on `flag_z` or `flag_c` one edge after the operation that wrote it. It also shows up in `result` in the same cycle as the next carry-fed rotate or merge, because those operations use the flag as fill or merge data. The bench therefore chains operations: one operation sets a flag value, and the next operation uses it. This way a flag corrupted by a wrong end bit or a wrong parity shows up in a later result. Held flags are checked after operations whose strobe was low.

// File: rtl/bitops_pkg.sv
package bitops_pkg;

    typedef enum logic [3:0] {
        OP_ROTR   = 4'd0,
        OP_ROTL   = 4'd1,
        OP_SHR    = 4'd2,
        OP_SHL    = 4'd3,
        OP_CROTR  = 4'd4,
        OP_CROTL  = 4'd5,
        OP_SAR    = 4'd6,
        OP_MIRROR = 4'd7,
        OP_ANDN   = 4'd8,
        OP_AND    = 4'd9,
        OP_OR     = 4'd10,
        OP_XOR    = 4'd11,
        OP_MRG_C  = 4'd12,
        OP_MRG_NC = 4'd13,
        OP_MRG_Z  = 4'd14,
        OP_MRG_NZ = 4'd15
    } op_e;

    typedef struct packed {
        logic z;
        logic c;
    } flags_t;

endpackage

// File: rtl/bitops_shift.sv
module bitops_shift #(
    parameter int W  = 32,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  d,
    input  logic [AW-1:0] amt,
    input  logic [2:0]    sel,
    input  logic          cin,
    output logic [W-1:0]  res,
    output logic          end_bit
);
    logic [2*W-1:0] dd_r, dd_l, cf_r, cf_l;
    logic [W-1:0]   mirrored;

    // mirror of d, built bit by bit
    for (genvar i = 0; i < W; i++) begin : g_mirror
        assign mirrored[i] = d[W-1-i];
    end

    always_comb begin
        dd_r = {d, d} >> amt;
        dd_l = {d, d} << amt;
        cf_r = {{W{cin}}, d} >> amt;
        cf_l = {d, {W{cin}}} << amt;
        unique case (sel)
            3'd0:    res = dd_r[W-1:0];
            3'd1:    res = dd_l[2*W-1:W];
            3'd2:    res = d >> amt;
            3'd3:    res = d << amt;
            3'd4:    res = cf_r[W-1:0];
            3'd5:    res = cf_l[2*W-1:W];
            3'd6:    res = $unsigned($signed(d) >>> amt);
            default: res = mirrored >> amt;
        endcase
        // right-moving ops and mirror report the low end, left ops the high end
        end_bit = (sel[0] == 1'b0 || sel == 3'd7) ? d[0] : d[W-1];
    end
endmodule

// File: rtl/bitops_logic.sv
module bitops_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0] d,
    input  logic [W-1:0] s,
    input  logic         merge,
    input  logic [1:0]   sel,
    input  logic         zin,
    input  logic         cin,
    output logic [W-1:0] res
);
    logic fill;

    always_comb begin
        unique case (sel)
            2'd0:    fill = cin;
            2'd1:    fill = ~cin;
            2'd2:    fill = zin;
            default: fill = ~zin;
        endcase
        if (merge) begin
            res = (d & ~s) | ({W{fill}} & s);
        end else begin
            unique case (sel)
                2'd0:    res = d & ~s;
                2'd1:    res = d & s;
                2'd2:    res = d | s;
                default: res = d ^ s;
            endcase
        end
    end
endmodule

// File: rtl/bitops_exec.sv
module bitops_exec #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] opd_d,
    input  logic [W-1:0] opd_s,
    input  logic [3:0]   op,
    input  logic         wr_z,
    input  logic         wr_c,
    output logic [W-1:0] result,
    output logic         flag_z,
    output logic         flag_c
);
    import bitops_pkg::*;
    localparam int AW = $clog2(W);

    flags_t       flg_d, flg_q;
    logic [W-1:0] sh_res, lg_res;
    logic         sh_end;
    op_e          op_sel;

    assign op_sel = op_e'(op);

    bitops_shift #(.W(W), .AW(AW)) shift_i (
        .d       (opd_d),
        .amt     (opd_s[AW-1:0]),
        .sel     (op[2:0]),
        .cin     (flg_q.c),
        .res     (sh_res),
        .end_bit (sh_end)
    );

    bitops_logic #(.W(W)) logic_i (
        .d     (opd_d),
        .s     (opd_s),
        .merge (op[2]),
        .sel   (op[1:0]),
        .zin   (flg_q.z),
        .cin   (flg_q.c),
        .res   (lg_res)
    );

    always_comb begin
        result = op_sel[3] ? lg_res : sh_res;
        flg_d  = flg_q;
        if (wr_z) flg_d.z = (result == '0);
        if (wr_c) flg_d.c = op_sel[3] ? ^result : sh_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign flag_z = flg_q.z;
    assign flag_c = flg_q.c;
endmodule

// File: rtl/bitops_exec_chk.sv
module bitops_exec_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] opd_d,
    input logic [W-1:0] opd_s,
    input logic [3:0]   op,
    input logic         wr_z,
    input logic         wr_c,
    input logic [W-1:0] result,
    input logic         flag_z,
    input logic         flag_c
);
    logic right_grp, left_grp;
    assign right_grp = (op == 4'd0) || (op == 4'd2) || (op == 4'd4) ||
                       (op == 4'd6) || (op == 4'd7);
    assign left_grp  = (op == 4'd1) || (op == 4'd3) || (op == 4'd5);

    AST_Z_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_z |=> flag_z == $past(flag_z)); // R11
    AST_C_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_c |=> flag_c == $past(flag_c)); // R11
    AST_Z_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_z |=> flag_z == ($past(result) == '0)); // R10
    AST_LOGIC_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_c && op[3]) |=> flag_c == ^$past(result)); // R8
    AST_RIGHT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_c && right_grp) |=> flag_c == $past(opd_d[0])); // R7
    AST_LEFT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_c && left_grp) |=> flag_c == $past(opd_d[W-1])); // R7
    AST_ZERO_AMT: assert property (@(posedge clk) disable iff (!rst_n)
        (op < 4'd7 && opd_s[4:0] == 5'd0) |-> result == opd_d); // R13
    AST_MERGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (op[3:2] == 2'b11) |-> ((result ^ opd_d) & ~opd_s) == '0); // R9
endmodule

bind bitops_exec bitops_exec_chk #(.W(W)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .opd_d  (opd_d),
    .opd_s  (opd_s),
    .op     (op),
    .wr_z   (wr_z),
    .wr_c   (wr_c),
    .result (result),
    .flag_z (flag_z),
    .flag_c (flag_c)
);

// File: tb/bitops_exec_tb_top.sv
`timescale 1ns/1ps
module bitops_exec_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opd_d = '0, opd_s = '0;
    logic [3:0]  op = '0;
    logic        wr_z = 1'b0, wr_c = 1'b0;
    logic [31:0] result;
    logic        flag_z, flag_c;

    int n_chk = 0, n_fail = 0;
    logic mz = 1'b0, mc = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] res;
        logic        z;
        logic        c;
        string       tag;
    } item_t;
    item_t q[$];

    always #2.5 clk = ~clk;

    bitops_exec dut_i (.clk(clk), .rst_n(rst_n), .opd_d(opd_d), .opd_s(opd_s),
        .op(op), .wr_z(wr_z), .wr_c(wr_c), .result(result),
        .flag_z(flag_z), .flag_c(flag_c));

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // bit-by-bit reference built from the requirement text
    function automatic logic [32:0] model(logic [3:0] o, logic [31:0] d,
                                          logic [31:0] s, logic z, logic c);
        int n = int'(s[4:0]);
        logic [31:0] r = '0;
        logic cy, f;
        for (int i = 0; i < 32; i++) begin
            case (o)
                4'd0: r[i] = d[(i + n) % 32];
                4'd1: r[i] = d[(i - n + 32) % 32];
                4'd2: r[i] = (i + n < 32) ? d[i + n] : 1'b0;
                4'd3: r[i] = (i >= n) ? d[i - n] : 1'b0;
                4'd4: r[i] = (i + n < 32) ? d[i + n] : c;
                4'd5: r[i] = (i >= n) ? d[i - n] : c;
                4'd6: r[i] = (i + n < 32) ? d[i + n] : d[31];
                4'd7: r[i] = (i <= 31 - n) ? d[31 - n - i] : 1'b0;
                4'd8: r[i] = d[i] & !s[i];
                4'd9: r[i] = d[i] & s[i];
                4'd10: r[i] = d[i] | s[i];
                4'd11: r[i] = d[i] ^ s[i];
                default: begin
                    f = (o == 4'd12) ? c : (o == 4'd13) ? !c : (o == 4'd14) ? z : !z;
                    r[i] = s[i] ? f : d[i];
                end
            endcase
        end
        if (o >= 4'd8) begin
            cy = 1'b0;
            for (int i = 0; i < 32; i++) cy = cy ^ r[i];
        end else if (o == 4'd1 || o == 4'd3 || o == 4'd5) cy = d[31];
        else cy = d[0];
        return {cy, r};
    endfunction

    // driver: apply one op and push the expected outcome
    task automatic drive(string tag, logic [3:0] o, logic [31:0] d, logic [31:0] s,
                         logic wz, logic wc);
        logic [32:0] m;
        item_t it;
        @(negedge clk);
        opd_d = d; opd_s = s; op = o; wr_z = wz; wr_c = wc;
        m = model(o, d, s, mz, mc);
        it.res = m[31:0];
        if (wz) mz = (m[31:0] == 32'd0);
        if (wc) mc = m[32];
        it.z = mz; it.c = mc; it.tag = tag;
        q.push_back(it);
    endtask

    // monitor: result before the edge, flags after it
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                it = q.pop_front();
                check({it.tag, " result"}, result, it.res);
                @(posedge clk);
                #1;
                check({it.tag, " flag_z"}, {31'd0, flag_z}, {31'd0, it.z});
                check({it.tag, " flag_c"}, {31'd0, flag_c}, {31'd0, it.c});
            end
        end
    end

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #12;
        check("R12 reset flag_z", {31'd0, flag_z}, 32'd0);
        check("R12 reset flag_c", {31'd0, flag_c}, 32'd0);
        rst_n = 1'b1;
        drive("R2 rotr",            4'd0, 32'h8000_0001, 32'd4, 1, 1);
        drive("R2 rotl",            4'd1, 32'h8000_0001, 32'd4, 1, 1);
        drive("R1 rotr upper S",    4'd0, 32'h1234_5678, 32'hFFFF_FFE8, 1, 1);
        drive("R3 shr",             4'd2, 32'hF000_000F, 32'd8, 1, 1);
        drive("R3 shl zero res",    4'd3, 32'h0000_00F0, 32'd28, 1, 1);
        drive("R7 set carry",       4'd2, 32'h0000_0001, 32'd1, 1, 1);
        drive("R4 crotr fill 1",    4'd4, 32'h0000_0100, 32'd4, 1, 0);
        drive("R4 crotl fill 1",    4'd5, 32'h0000_0001, 32'd3, 1, 1);
        drive("R5 sar neg",         4'd6, 32'h8000_0010, 32'd4, 1, 1);
        drive("R5 sar pos",         4'd6, 32'h4000_0000, 32'd31, 1, 1);
        drive("R6 mirror n0",       4'd7, 32'h0000_0001, 32'd0, 1, 1);
        drive("R6 mirror n31",      4'd7, 32'hFFFF_FFFE, 32'd31, 1, 1);
        drive("R6 mirror n8",       4'd7, 32'h00C0_0003, 32'd8, 1, 1);
        drive("R13 rotl n0",        4'd1, 32'h8000_0000, 32'd0, 1, 1);
        drive("R13 shr n0",         4'd2, 32'hA5A5_A5A4, 32'h40, 1, 1);
        drive("R8 andn",            4'd8, 32'hFF00_FF00, 32'h0F0F_0F0F, 1, 1);
        drive("R8 and",             4'd9, 32'hFF00_FF00, 32'h0F0F_0F0F, 1, 1);
        drive("R8 or",              4'd10, 32'h0000_0001, 32'h0000_0002, 1, 1);
        drive("R8 xor zero",        4'd11, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1, 1);
        drive("R9 merge c",         4'd12, 32'h0000_0000, 32'h0000_00FF, 1, 1);
        drive("R9 merge nc",        4'd13, 32'hFFFF_0000, 32'hF0F0_F0F0, 1, 1);
        drive("R9 merge z",         4'd14, 32'h1111_1111, 32'h0000_FFFF, 1, 1);
        drive("R9 merge nz",        4'd15, 32'h1111_1111, 32'hFFFF_0000, 1, 1);
        drive("R11 hold both",      4'd3, 32'h0000_0000, 32'd1, 0, 0);
        drive("R11 hold z write c", 4'd1, 32'h8000_0000, 32'd1, 0, 1);
        drive("R10 z after hold",   4'd2, 32'h0000_0000, 32'd3, 1, 0);
        drive("R4 crotr uses held", 4'd4, 32'h0000_0000, 32'd31, 1, 1);
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule